// File: doc/BRIEF.md
# Prefetch Readback Gateway Across Clock Domains

This block lets a local register bus read values that live in a separate application clock domain without sampling those values across the clock boundary. A one-cycle prefill pulse on the bus side asks for a refresh. The request crosses into the application domain as a toggle through a two-flop synchronizer. An application-side sequencer then steps an external 16-input, 32-bit multiplexer through all of its inputs, one per cycle, and writes each returned word into a 16-entry mirror RAM. Bus reads are then served from the mirror with a fixed latency of one cycle. The prefill is issued during the lead time before the first read of a transaction, so every read in that transaction finds fresh data.

The application sequencer has three states. SEQ_IDLE waits for a request. SEQ_SCAN strobes addresses 0 to 15. SEQ_FLUSH writes the last returned word and then toggles a completion flag. The transitions are IDLE→SCAN on a synchronized request, SCAN→FLUSH after address 15, and FLUSH→IDLE unconditionally. The bus-side controller also has three states. BUS_EMPTY means no copy has been made since reset. BUS_FILL means a copy has been requested and has not yet completed. BUS_VALID means the mirror holds a finished copy. The transitions are EMPTY→FILL and VALID→FILL on a prefill, and FILL→VALID when the synchronized completion toggle changes. A read in BUS_FILL breaks the timing assumption and raises a sticky error.

A parameter selects a legacy mode that wires the bus straight to the multiplexer. That mode is not safe across clock domains.

Top module: `readback_gateway`

## Requirements
- R1: With PASSTHROUGH=0, a bus read of index `lb_addr` (4 bits) returns the 32-bit word that the multiplexer returned for that index during the most recently completed copy.
- R2: `lb_rdata` changes only at the lb_clk edge where `lb_strobe` is high, so read data is valid one cycle after the strobe. Without a strobe, the output holds its value.
- R3: A copy drives `mux_strobe` high for 16 consecutive app_clk cycles with `mux_addr` counting 0,1,…,15. The multiplexer returns `mux_rdata` one mux_clk cycle after each strobe, and that word is written to the mirror at the strobed index.
- R4: A prefill accepted in BUS_EMPTY or BUS_VALID moves the bus controller to BUS_FILL and reaches the application domain through a toggle synchronizer. Completion returns the same way and moves the controller to BUS_VALID.
- R5: Once a copy is complete, repeated reads of one index return the same value until the next prefill, even if the multiplexer inputs change.
- R6: A bus read while in BUS_FILL sets `lb_err`. The flag stays set until the next accepted prefill, which clears it at the same edge.
- R7: `snap` is high for exactly one app_clk cycle at the start of each copy, in the cycle of the first strobe (index 0).
- R8: A prefill that arrives while a copy is pending or running is ignored. It produces no extra `snap`, no extra strobes, and no restart of the address count.
- R9: After reset, `lb_rdata` and `lb_err` are 0, `mux_strobe` is 0, and every mirror word is 0, so a read before any prefill returns 0.
- R10: With PASSTHROUGH=1, `mux_clk` is lb_clk, `mux_strobe` and `mux_addr` follow `lb_strobe` and `lb_addr` combinationally, `lb_rdata` equals `mux_rdata`, and `lb_err` and `snap` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lb_clk | input | 1 | Bus clock |
| lb_rst_n | input | 1 | Bus-domain active-low reset |
| lb_addr | input | 4 | Read index into the mirror |
| lb_strobe | input | 1 | Read strobe |
| lb_prefill | input | 1 | Request to refresh the mirror |
| lb_rdata | output | 32 | Read data, one cycle after the strobe |
| lb_err | output | 1 | Sticky flag: a read arrived during a copy |
| app_clk | input | 1 | Application clock |
| app_rst_n | input | 1 | Application-domain active-low reset |
| mux_clk | output | 1 | Clock for the external multiplexer |
| mux_strobe | output | 1 | Multiplexer select strobe |
| mux_addr | output | 4 | Multiplexer input index |
| mux_rdata | input | 32 | Word returned by the multiplexer |
| snap | output | 1 | One-cycle pulse at the start of a copy |

## Verification
The hardest situation to reach from the ports is a second prefill that lands while a copy is still in flight. The bus controller cannot accept it, so its effect shows only in the strobe and snap counts in the other clock domain. The bench issues a prefill, repeats it two bus cycles later, and then counts exactly 16 strobes and one snap pulse. The sticky error is reached in a similar way: a read is issued the cycle after a prefill, and the bench then checks that `lb_err` survives the rest of the copy and clears only on the next accepted prefill.

// File: rtl/gw_pkg.sv
package gw_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SCAN  = 2'd1,
        SEQ_FLUSH = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        BUS_EMPTY = 2'd0,
        BUS_FILL  = 2'd1,
        BUS_VALID = 2'd2
    } bus_state_t;
endpackage

// File: rtl/gw_sync.sv
module gw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gw_mirror.sv
module gw_mirror #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n)  rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_idx];
    end
endmodule

// File: rtl/gw_copy_seq.sv
module gw_copy_seq
    import gw_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int IDX_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_tgl_async,
    output logic              mux_strobe,
    output logic [IDX_W-1:0]  mux_addr,
    input  logic [DATA_W-1:0] mux_rdata,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              snap,
    output logic              done_tgl
);
    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    seq_state_t       state, state_nx;
    logic             req_s, req_d, start;
    logic [IDX_W-1:0] cnt;

    gw_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .d_async(req_tgl_async), .q(req_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_d <= 1'b0;
        else        req_d <= req_s;
    end
    assign start = req_s ^ req_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE:  if (start) state_nx = SEQ_SCAN;
            SEQ_SCAN:  if (cnt == LAST_IDX) state_nx = SEQ_FLUSH;
            SEQ_FLUSH: state_nx = SEQ_IDLE;
            default:   state_nx = SEQ_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            snap     <= 1'b0;
            done_tgl <= 1'b0;
        end else begin
            wr_en  <= (state == SEQ_SCAN);
            wr_idx <= cnt;
            snap   <= (state == SEQ_IDLE) && start;
            unique case (state)
                SEQ_IDLE:  cnt <= '0;
                SEQ_SCAN:  cnt <= cnt + 1'b1;
                SEQ_FLUSH: done_tgl <= ~done_tgl;
                default:   cnt <= '0;
            endcase
        end
    end

    assign mux_strobe = (state == SEQ_SCAN);
    assign mux_addr   = cnt;
    assign wr_data    = mux_rdata;

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_strobe && mux_addr != LAST_IDX) |=>
            (mux_strobe && mux_addr == $past(mux_addr) + 1'b1));
    assert_write_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mux_strobe |=> (wr_en && wr_idx == $past(mux_addr)));
    assert_snap_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> !snap);
    assert_snap_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        snap |-> (mux_strobe && mux_addr == '0));
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_strobe && start) |=>
            (state == SEQ_FLUSH || mux_addr == $past(mux_addr) + 1'b1));
endmodule

// File: rtl/gw_bus_ctrl.sv
module gw_bus_ctrl
    import gw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prefill,
    input  logic strobe,
    input  logic done_tgl_async,
    output logic req_tgl,
    output logic err
);
    bus_state_t state, state_nx;
    logic       done_s, done_d, done_evt, accept;

    gw_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk(clk), .rst_n(rst_n), .d_async(done_tgl_async), .q(done_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_d <= 1'b0;
        else        done_d <= done_s;
    end
    assign done_evt = done_s ^ done_d;
    assign accept   = prefill && (state != BUS_FILL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BUS_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            BUS_EMPTY: if (prefill)  state_nx = BUS_FILL;
            BUS_FILL:  if (done_evt) state_nx = BUS_VALID;
            BUS_VALID: if (prefill)  state_nx = BUS_FILL;
            default:   state_nx = BUS_EMPTY;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_tgl <= 1'b0;
            err     <= 1'b0;
        end else begin
            if (accept) req_tgl <= ~req_tgl;
            if (accept)                               err <= 1'b0;
            else if (strobe && state == BUS_FILL)     err <= 1'b1;
        end
    end

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !prefill) |=> err);
    assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!err && !(strobe && state == BUS_FILL)) |=> !err);
    assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !err);
    assert_prefill_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BUS_FILL && prefill) |=> $stable(req_tgl));
    assert_fill_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(req_tgl) |-> state == BUS_FILL);
endmodule

// File: rtl/readback_gateway.sv
module readback_gateway #(
    parameter int DATA_W      = 32,
    parameter int IDX_W       = 4,
    parameter int SYNC_STAGES = 2,
    parameter bit PASSTHROUGH = 1'b0
) (
    input  logic              lb_clk,
    input  logic              lb_rst_n,
    input  logic [IDX_W-1:0]  lb_addr,
    input  logic              lb_strobe,
    input  logic              lb_prefill,
    output logic [DATA_W-1:0] lb_rdata,
    output logic              lb_err,
    input  logic              app_clk,
    input  logic              app_rst_n,
    output logic              mux_clk,
    output logic              mux_strobe,
    output logic [IDX_W-1:0]  mux_addr,
    input  logic [DATA_W-1:0] mux_rdata,
    output logic              snap
);
    generate
        if (PASSTHROUGH) begin : g_direct
            logic unused_direct;
            assign unused_direct = ^{app_clk, app_rst_n, lb_prefill, lb_rst_n};
            assign mux_clk    = lb_clk;
            assign mux_strobe = lb_strobe;
            assign mux_addr   = lb_addr;
            assign lb_rdata   = mux_rdata;
            assign lb_err     = 1'b0;
            assign snap       = 1'b0;
        end else begin : g_mirror
            logic              req_tgl, done_tgl, wr_en;
            logic [IDX_W-1:0]  wr_idx;
            logic [DATA_W-1:0] wr_data;

            assign mux_clk = app_clk;

            gw_bus_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_bus (
                .clk(lb_clk), .rst_n(lb_rst_n), .prefill(lb_prefill),
                .strobe(lb_strobe), .done_tgl_async(done_tgl),
                .req_tgl(req_tgl), .err(lb_err)
            );

            gw_copy_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W), .SYNC_STAGES(SYNC_STAGES)) u_seq (
                .clk(app_clk), .rst_n(app_rst_n), .req_tgl_async(req_tgl),
                .mux_strobe(mux_strobe), .mux_addr(mux_addr), .mux_rdata(mux_rdata),
                .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
                .snap(snap), .done_tgl(done_tgl)
            );

            gw_mirror #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mem (
                .wr_clk(app_clk), .wr_rst_n(app_rst_n), .wr_en(wr_en),
                .wr_idx(wr_idx), .wr_data(wr_data),
                .rd_clk(lb_clk), .rd_rst_n(lb_rst_n), .rd_en(lb_strobe),
                .rd_idx(lb_addr), .rd_data(lb_rdata)
            );

            assert_hold_R2: assert property (@(posedge lb_clk) disable iff (!lb_rst_n)
                !lb_strobe |=> $stable(lb_rdata));
        end
    endgenerate
endmodule

// File: tb/readback_gateway_bench.sv
module readback_gateway_bench;
    logic        lb_clk = 0, app_clk = 0;
    logic        lb_rst_n = 0, app_rst_n = 0;
    logic [3:0]  lb_addr = 0;
    logic        lb_strobe = 0, lb_prefill = 0;
    logic [31:0] lb_rdata, pt_rdata;
    logic        lb_err, pt_err, mux_clk, pt_mux_clk;
    logic        mux_strobe, pt_strobe, snap, pt_snap;
    logic [3:0]  mux_addr, pt_addr;
    logic [31:0] mux_rdata = 0, pt_mux_rdata = 0;
    logic [7:0]  gen = 8'h00;

    int checks = 0, errors = 0;
    int strobe_cnt = 0, snap_cnt = 0;
    bit finished = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          pend = 0;

    always #5 lb_clk  = ~lb_clk;   // 100 MHz
    always #3.5 app_clk = ~app_clk;

    readback_gateway u_readback_gateway (
        .lb_clk(lb_clk), .lb_rst_n(lb_rst_n), .lb_addr(lb_addr), .lb_strobe(lb_strobe),
        .lb_prefill(lb_prefill), .lb_rdata(lb_rdata), .lb_err(lb_err),
        .app_clk(app_clk), .app_rst_n(app_rst_n), .mux_clk(mux_clk),
        .mux_strobe(mux_strobe), .mux_addr(mux_addr), .mux_rdata(mux_rdata), .snap(snap)
    );

    readback_gateway #(.PASSTHROUGH(1'b1)) u_readback_gateway_pt (
        .lb_clk(lb_clk), .lb_rst_n(lb_rst_n), .lb_addr(lb_addr), .lb_strobe(lb_strobe),
        .lb_prefill(lb_prefill), .lb_rdata(pt_rdata), .lb_err(pt_err),
        .app_clk(app_clk), .app_rst_n(app_rst_n), .mux_clk(pt_mux_clk),
        .mux_strobe(pt_strobe), .mux_addr(pt_addr), .mux_rdata(pt_mux_rdata), .snap(pt_snap)
    );

    function automatic logic [31:0] word(input logic [7:0] g, input logic [3:0] a);
        return {g, 8'h5A, 12'h000, a};
    endfunction

    // external multiplexer models, one-cycle registered return
    always @(posedge mux_clk) if (mux_strobe) mux_rdata <= word(gen, mux_addr);
    always @(posedge pt_mux_clk) if (pt_strobe) pt_mux_rdata <= {16'hC0DE, 12'h000, pt_addr};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // application-domain monitor: strobe order (R3) and snap count (R7)
    always @(negedge app_clk) begin
        if (app_rst_n && mux_strobe) begin
            check("R3", {28'h0, mux_addr}, strobe_cnt % 16);
            strobe_cnt++;
        end
        if (app_rst_n && snap) begin
            check("R7", {28'h0, mux_addr}, 32'h0);
            snap_cnt++;
        end
    end

    // scoreboard monitor: data one cycle after strobe (R2)
    always @(negedge lb_clk) begin
        if (pend) begin
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2 actual=%h expected=<empty queue>", lb_rdata);
            end else begin
                check(tag_q.pop_front(), lb_rdata, exp_q.pop_front());
            end
        end
        pend = lb_strobe && (exp_q.size() != 0);
    end

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(posedge lb_clk); #1;
        lb_addr = a; lb_strobe = 1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge lb_clk); #1;
        lb_strobe = 0;
    endtask

    task automatic rd_nocheck(input logic [3:0] a);
        @(posedge lb_clk); #1;
        lb_addr = a; lb_strobe = 1;
        @(posedge lb_clk); #1;
        lb_strobe = 0;
    endtask

    task automatic prefill();
        @(posedge lb_clk); #1;
        lb_prefill = 1;
        @(posedge lb_clk); #1;
        lb_prefill = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge lb_clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge lb_clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int s0, n0;
        idle(3);
        lb_rst_n = 1; app_rst_n = 1;
        idle(2);
        @(negedge lb_clk);
        // R9: reset state
        check("R9 rdata", lb_rdata, 0);
        check("R9 err", {31'h0, lb_err}, 0);
        check("R9 strobe", {31'h0, mux_strobe}, 0);
        rd(4'd7, 32'h0, "R9 empty read");

        // R1/R4: first copy then full readout
        gen = 8'h11;
        prefill();
        idle(40);
        check("R4 one copy", strobe_cnt, 16);
        for (int a = 0; a < 16; a++) rd(a[3:0], word(8'h11, a[3:0]), "R1");
        idle(2);

        // R2: hold without strobe
        lb_addr = 4'd2;
        idle(3);
        @(negedge lb_clk);
        check("R2 hold", lb_rdata, word(8'h11, 4'd15));

        // R5: source changes, mirror repeats
        gen = 8'h22;
        rd(4'd3, word(8'h11, 4'd3), "R5");
        rd(4'd3, word(8'h11, 4'd3), "R5");
        prefill();
        idle(40);
        rd(4'd3, word(8'h22, 4'd3), "R5 refreshed");
        rd(4'd12, word(8'h22, 4'd12), "R1 refreshed");
        idle(2);

        // R6: read during copy
        gen = 8'h33;
        prefill();
        rd_nocheck(4'd1);
        @(negedge lb_clk);
        check("R6 set", {31'h0, lb_err}, 1);
        idle(40);
        @(negedge lb_clk);
        check("R6 sticky", {31'h0, lb_err}, 1);
        rd(4'd9, word(8'h33, 4'd9), "R6 data after copy");
        idle(2);
        @(posedge lb_clk); #1; lb_prefill = 1;
        @(negedge lb_clk);
        check("R6 held until edge", {31'h0, lb_err}, 1);
        @(posedge lb_clk); #1; lb_prefill = 0;
        @(negedge lb_clk);
        check("R6 cleared", {31'h0, lb_err}, 0);
        idle(40);

        // R8: second prefill during a copy is ignored
        s0 = strobe_cnt; n0 = snap_cnt;
        gen = 8'h44;
        prefill();
        idle(1);
        prefill();
        idle(50);
        check("R8 strobes", strobe_cnt - s0, 16);
        check("R8 snaps", snap_cnt - n0, 1);
        check("R7 snap per copy", snap_cnt, 5);
        rd(4'd0, word(8'h44, 4'd0), "R8 data");
        rd(4'd15, word(8'h44, 4'd15), "R8 data");
        idle(2);

        // R10: passthrough variant
        @(posedge lb_clk); #1;
        lb_addr = 4'd9; lb_strobe = 1;
        #1;
        check("R10 strobe", {31'h0, pt_strobe}, 1);
        check("R10 addr", {28'h0, pt_addr}, 9);
        exp_q.push_back(word(8'h44, 4'd9)); tag_q.push_back("R1 with R10");
        @(negedge lb_clk);
        @(posedge lb_clk); #1;
        lb_strobe = 0;
        @(negedge lb_clk);
        check("R10 data", pt_rdata, {16'hC0DE, 12'h000, 4'd9});
        check("R10 err", {30'h0, pt_err, pt_snap}, 0);
        idle(3);

        check("scoreboard drained", exp_q.size(), 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule